// File: doc/BRIEF.md
# Clock-Mapped Byte SRAM

A byte-wide static memory whose highest eight addresses form a window onto a separate timekeeping counter block. The host sees one flat array: ordinary locations behave as plain storage, and the eight window bytes read and write like any other cell. The window bytes do not count. They hold a copy of the counters, which is refreshed once per second from the counters' parallel read port. Values the host writes into the window are pushed into the counters in a single parallel load.

The lowest window byte is a control byte. Its two top bits suspend the once-per-second refresh. One gives the host a stable snapshot while the counters keep running. The other lets the host rewrite the time, and clearing it triggers the load. The low six bits hold a signed calibration value for the oscillator trim. A stop flag in the seconds byte gates the counters' enable. A test flag in the day-of-week byte drives a frequency-test pin. A power-fail input blocks every write.

Top module: `rtc_mapped_sram`

## Requirements
- R1: A write with `ce` and `we` high stores `wdata` at `addr`. A read with `ce` and `oe` high and `we` low returns the stored byte on `rdata` at the next clock edge, with `rdata_oe` high for that cycle.
- R2: `rdata_oe` is high only in the cycle after a read cycle. It is low after a cycle with `ce` low, `oe` low or `we` high.
- R3: The top eight addresses (window index 0 to 7, index = address minus depth plus 8) read and write like plain storage.
- R4: Window index 0 is the control byte: bit 7 is the write-hold flag, bit 6 is the read-hold flag, and bits 5..0 appear on `cal`.
- R5: A `tick_1hz` pulse sets a pending refresh. In the next cycle with both hold flags clear, window bytes 1..7 take the counter bytes from `cnt_q` (byte k at bits 8k-1..8k-8). Index 0 is never refreshed.
- R6: While either hold flag is set, no refresh occurs and the window bytes keep their values. A tick seen during the hold stays pending, and the refresh after the flags clear uses the `cnt_q` of that cycle.
- R7: A write to the control byte that clears bit 7 while it was set pulses `cnt_load` for one cycle, one edge later. `cnt_ld_data` then carries window bytes 1..7 in the `cnt_q` layout, and any pending refresh is dropped.
- R8: Bit 7 of window byte 1 (seconds) is the stop flag, and `cnt_run` is its inverse. A refresh keeps this bit.
- R9: Bit 6 of window byte 4 (day of week) drives `freq_test`. A refresh keeps this bit.
- R10: While `pfail` is high, every write is ignored: plain storage, window bytes and the control byte.
- R11: When a host write to a window byte falls in the same cycle as a refresh, the host value is kept.
- R12: After reset, all window bytes and the control byte are zero, no refresh is pending, `rdata_oe` and `cnt_load` are low, and `cnt_run` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid while `rdata_oe` is high |
| rdata_oe | output | 1 | Output drive enable; low means the data bus is released |
| ce | input | 1 | Chip enable |
| oe | input | 1 | Output enable |
| we | input | 1 | Write enable |
| pfail | input | 1 | Power-fail; blocks all writes |
| tick_1hz | input | 1 | One-cycle pulse, once per second, from the counter block |
| cnt_q | input | 7*DATA_W | Live counter bytes 1..7 |
| cnt_load | output | 1 | One-cycle parallel load strobe to the counters |
| cnt_ld_data | output | 7*DATA_W | Bytes to load into the counters |
| cnt_run | output | 1 | Counter enable (inverse of the stop flag) |
| freq_test | output | 1 | Frequency-test pin |
| cal | output | 6 | Calibration value (sign and magnitude) |

## Verification
The bench builds the block with `ADDR_W` = 8, which gives 256 bytes with the window at 0xF8 to 0xFF. With this size, random traffic lands in the window about half the time and still covers plain storage densely. Random control writes, ticks, power-fail pulses and changing counter values make holds, pending ticks, load strobes and write-versus-refresh collisions happen often. Directed phases first reach each of these cases in turn.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
  localparam int NCLK   = 8;   // window size in bytes
  localparam int IDX_W  = $clog2(NCLK);
  localparam int CAL_W  = 6;
  localparam int IX_CTL = 0;
  localparam int IX_SEC = 1;
  localparam int IX_DAY = 4;
  localparam int B_WHOLD = 7;  // control: write hold
  localparam int B_RHOLD = 6;  // control: read hold
  localparam int B_STOP  = 7;  // seconds byte
  localparam int B_FTEST = 6;  // day byte
endpackage

// File: rtl/rtcs_sram.sv
module rtcs_sram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= wdata;
    if (rd) q <= mem[addr];
  end
endmodule

// File: rtl/rtcs_clock_regs.sv
module rtcs_clock_regs
  import rtcs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      widx,
  input  logic [DW-1:0]         wdata,
  input  logic [IDX_W-1:0]      ridx,
  output logic [DW-1:0]         rbyte,
  input  logic                  tick,
  input  logic [(NCLK-1)*DW-1:0] cnt_q,
  output logic [DW-1:0]         ctrl,
  output logic                  cnt_load,
  output logic [(NCLK-1)*DW-1:0] cnt_ld_data,
  output logic                  cnt_run,
  output logic                  freq_test
);
  localparam int PKW = (NCLK-1)*DW;

  logic [DW-1:0]  regs [NCLK];
  logic [DW-1:0]  snap [1:NCLK-1];
  logic [PKW-1:0] cur_pk;
  logic           pend, hold, refresh, w_fall;

  assign hold    = regs[IX_CTL][B_WHOLD] | regs[IX_CTL][B_RHOLD];
  assign refresh = pend & ~hold;
  assign w_fall  = wr_en && (widx == IX_CTL[IDX_W-1:0]) &&
                   regs[IX_CTL][B_WHOLD] && !wdata[B_WHOLD];

  for (genvar k = 1; k < NCLK; k++) begin : g_byte
    always_comb begin
      snap[k] = cnt_q[(k-1)*DW +: DW];
      if (k == IX_SEC) snap[k][B_STOP]  = regs[k][B_STOP];
      if (k == IX_DAY) snap[k][B_FTEST] = regs[k][B_FTEST];
    end
    assign cur_pk[(k-1)*DW +: DW] = regs[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NCLK; k++) regs[k] <= '0;
      pend        <= 1'b0;
      cnt_load    <= 1'b0;
      cnt_ld_data <= '0;
    end else begin
      pend <= w_fall ? 1'b0 : ((pend & hold) | tick);
      if (refresh)
        for (int k = 1; k < NCLK; k++) regs[k] <= snap[k];
      if (wr_en) regs[widx] <= wdata;   // host beats refresh
      cnt_load <= w_fall;
      if (w_fall) cnt_ld_data <= cur_pk;
    end
  end

  assign rbyte     = regs[ridx];
  assign ctrl      = regs[IX_CTL];
  assign cnt_run   = ~regs[IX_SEC][B_STOP];
  assign freq_test = regs[IX_DAY][B_FTEST];

  // R6
  hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !wr_en) |=> $stable(cur_pk));
  // R7
  load_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_load |-> (!ctrl[B_WHOLD] && $past(ctrl[B_WHOLD])));
  // R7
  load_single_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_load |=> !cnt_load);
endmodule

// File: rtl/rtc_mapped_sram.sv
module rtc_mapped_sram
  import rtcs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic                      rdata_oe,
  input  logic                      ce,
  input  logic                      oe,
  input  logic                      we,
  input  logic                      pfail,
  input  logic                      tick_1hz,
  input  logic [(NCLK-1)*DATA_W-1:0] cnt_q,
  output logic                      cnt_load,
  output logic [(NCLK-1)*DATA_W-1:0] cnt_ld_data,
  output logic                      cnt_run,
  output logic                      freq_test,
  output logic [CAL_W-1:0]          cal
);
  logic              in_win, rd, wr_ok;
  logic [DATA_W-1:0] mem_q, win_byte, win_q, ctrl_byte;
  logic              sel_win;

  assign in_win = &addr[ADDR_W-1:IDX_W];
  assign rd     = ce & oe & ~we;
  assign wr_ok  = ce & we & ~pfail;

  rtcs_sram #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk   (clk),
    .wr    (wr_ok & ~in_win),
    .rd    (rd & ~in_win),
    .addr  (addr),
    .wdata (wdata),
    .q     (mem_q)
  );

  rtcs_clock_regs #(.DW(DATA_W)) u_window (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_ok & in_win),
    .widx        (addr[IDX_W-1:0]),
    .wdata       (wdata),
    .ridx        (addr[IDX_W-1:0]),
    .rbyte       (win_byte),
    .tick        (tick_1hz),
    .cnt_q       (cnt_q),
    .ctrl        (ctrl_byte),
    .cnt_load    (cnt_load),
    .cnt_ld_data (cnt_ld_data),
    .cnt_run     (cnt_run),
    .freq_test   (freq_test)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_oe <= 1'b0;
      sel_win  <= 1'b0;
      win_q    <= '0;
    end else begin
      rdata_oe <= rd;
      if (rd) begin
        sel_win <= in_win;
        win_q   <= win_byte;
      end
    end
  end

  assign rdata = sel_win ? win_q : mem_q;
  assign cal   = ctrl_byte[CAL_W-1:0];

  // R2
  drive_only_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> $past(ce && oe && !we));
  // R10
  pfail_blocks_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    pfail |=> $stable(ctrl_byte));
endmodule

// File: tb/test_rtc_mapped_sram.sv
`timescale 1ns/1ps
module test_rtc_mapped_sram;
  localparam int AW = 8, DW = 8, NB = 8, BASE = (1 << AW) - NB;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [AW-1:0]   addr = '0;
  logic [DW-1:0]   wdata = '0, rdata;
  logic            rdata_oe, ce = 0, oe = 0, we = 0, pfail = 0, tick_1hz = 0;
  logic [7*DW-1:0] cnt_q = '0, cnt_ld_data;
  logic            cnt_load, cnt_run, freq_test;
  logic [5:0]      cal;

  rtc_mapped_sram #(.ADDR_W(AW), .DATA_W(DW)) i_rtc_mapped_sram (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .ce(ce), .oe(oe), .we(we), .pfail(pfail),
    .tick_1hz(tick_1hz), .cnt_q(cnt_q), .cnt_load(cnt_load),
    .cnt_ld_data(cnt_ld_data), .cnt_run(cnt_run), .freq_test(freq_test),
    .cal(cal));

  // reference model state
  logic [7:0]      m_mem [0:(1<<AW)-1];
  bit              m_val [0:(1<<AW)-1];
  logic [7:0]      m_ck  [0:NB-1];
  bit              m_pend;
  bit              e_doe, e_rdv, e_rdwin, e_ld;
  logic [7:0]      e_rd;
  logic [7*DW-1:0] e_ldd;
  int vectors = 0, miss = 0;
  string tag = "R12";
  bit done = 0;

  initial for (int i = 0; i < (1<<AW); i++) m_val[i] = 0;

  always @(posedge clk) begin
    bit h, wr, wfall;
    logic [7:0] v;
    if (rst) begin
      for (int k = 0; k < NB; k++) m_ck[k] = 8'h00;
      m_pend = 0; e_doe = 0; e_ld = 0; e_ldd = '0;
    end else begin
      h     = m_ck[0][7] | m_ck[0][6];
      wr    = ce && we && !pfail;
      wfall = wr && (int'(addr) == BASE) && m_ck[0][7] && !wdata[7];
      if (ce && oe && !we) begin
        e_doe = 1;
        if (int'(addr) >= BASE) begin
          e_rd = m_ck[int'(addr) - BASE]; e_rdv = 1; e_rdwin = 1;
        end else begin
          e_rd = m_mem[addr]; e_rdv = m_val[addr]; e_rdwin = 0;
        end
      end else e_doe = 0;
      e_ld = wfall;
      if (wfall) for (int k = 1; k < NB; k++) e_ldd[(k-1)*8 +: 8] = m_ck[k];
      if (m_pend && !h)
        for (int k = 1; k < NB; k++) begin
          v = cnt_q[(k-1)*8 +: 8];
          if (k == 1) v[7] = m_ck[1][7];
          if (k == 4) v[6] = m_ck[4][6];
          m_ck[k] = v;
        end
      m_pend = wfall ? 0 : ((m_pend && h) || tick_1hz);
      if (wr) begin
        if (int'(addr) >= BASE) m_ck[int'(addr) - BASE] = wdata;
        else begin m_mem[addr] = wdata; m_val[addr] = 1; end
      end
    end
  end

  task automatic chk(string req, string nm, logic [63:0] got, logic [63:0] exp);
    if (got !== exp) begin
      miss++;
      $display("FAIL %s [%s] %s: got %h expected %h at %0t", req, tag, nm, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      chk("R12/R8", "cnt_run",   64'(cnt_run),   64'(!m_ck[1][7]));
      chk("R9",     "freq_test", 64'(freq_test), 64'(m_ck[4][6]));
      chk("R4",     "cal",       64'(cal),       64'(m_ck[0][5:0]));
      chk("R2",     "rdata_oe",  64'(rdata_oe),  64'(e_doe));
      chk("R7",     "cnt_load",  64'(cnt_load),  64'(e_ld));
      if (e_ld) chk("R7", "cnt_ld_data", 64'(cnt_ld_data), 64'(e_ldd));
      if (e_doe && e_rdv)
        chk(e_rdwin ? "R3" : "R1", "rdata", 64'(rdata), 64'(e_rd));
    end
  end

  task automatic hwr(int a, logic [7:0] d);
    addr = a[AW-1:0]; wdata = d; ce = 1; we = 1; oe = 0;
    @(negedge clk); ce = 0; we = 0;
  endtask

  task automatic hrd(int a);
    addr = a[AW-1:0]; ce = 1; oe = 1; we = 0;
    @(negedge clk); ce = 0; oe = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  endtask

  initial begin
    #(150000.0 * 5.0);
    miss++;
    $display("FAIL watchdog expired [%s]", tag);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    tag = "R12"; repeat (2) @(negedge clk);
    for (int i = 0; i < NB; i++) hrd(BASE + i);

    tag = "R1";
    for (int i = 0; i < 16; i++) hwr(i * 13, 8'(i * 37 + 5));
    for (int i = 0; i < 16; i++) hrd(i * 13);
    hwr(BASE - 1, 8'hA5); hrd(BASE - 1);

    tag = "R2";
    addr = 8'd13; ce = 0; oe = 1; @(negedge clk);
    ce = 1; oe = 0; @(negedge clk);
    ce = 1; oe = 1; we = 1; wdata = 8'h11; @(negedge clk);
    ce = 0; oe = 0; we = 0; @(negedge clk);

    tag = "R3";
    for (int i = 1; i < NB; i++) hwr(BASE + i, 8'(8'h10 * i + i));
    for (int i = 0; i < NB; i++) hrd(BASE + i);

    tag = "R4"; hwr(BASE, 8'h25); hrd(BASE); hwr(BASE, 8'h00);

    tag = "R5";
    cnt_q = 56'h23_11_05_03_14_59_30;
    tick_1hz = 1; @(negedge clk); tick_1hz = 0;
    repeat (2) @(negedge clk);
    for (int i = 1; i < NB; i++) hrd(BASE + i);

    tag = "R6";
    hwr(BASE, 8'h40);
    tick_1hz = 1; @(negedge clk); tick_1hz = 0;
    cnt_q = 56'h24_12_31_07_23_58_45;
    repeat (3) @(negedge clk);
    for (int i = 1; i < NB; i++) hrd(BASE + i);
    cnt_q = 56'h24_12_31_07_23_59_01;
    hwr(BASE, 8'h00); repeat (2) @(negedge clk);
    for (int i = 1; i < NB; i++) hrd(BASE + i);

    tag = "R7";
    hwr(BASE, 8'h80);
    for (int i = 1; i < NB; i++) hwr(BASE + i, 8'(8'h21 + i));
    tick_1hz = 1; @(negedge clk); tick_1hz = 0;
    hwr(BASE, 8'h03); repeat (3) @(negedge clk);
    for (int i = 1; i < NB; i++) hrd(BASE + i);

    tag = "R8";
    hwr(BASE + 1, 8'h80);
    tick_1hz = 1; @(negedge clk); tick_1hz = 0;
    repeat (2) @(negedge clk); hrd(BASE + 1);

    tag = "R9";
    hwr(BASE + 4, 8'h40);
    tick_1hz = 1; @(negedge clk); tick_1hz = 0;
    repeat (2) @(negedge clk); hrd(BASE + 4);

    tag = "R10";
    pfail = 1;
    hwr(13, 8'hEE); hwr(BASE + 2, 8'hEE); hwr(BASE, 8'h80);
    pfail = 0;
    hrd(13); hrd(BASE + 2); hrd(BASE);

    tag = "R11";
    cnt_q = 56'h01_02_03_04_05_06_07;
    tick_1hz = 1; @(negedge clk); tick_1hz = 0;
    hwr(BASE + 2, 8'h33); hrd(BASE + 2); hrd(BASE + 3);

    tag = "random";
    for (int i = 0; i < 6000; i++) begin
      ce    = ($urandom % 4) != 0;
      we    = ($urandom % 3) == 0;
      oe    = ($urandom % 2) == 0;
      addr  = ($urandom % 2) ? 8'(BASE + $urandom % NB) : 8'($urandom % 24);
      wdata = 8'($urandom);
      if (int'(addr) == BASE && ($urandom % 2)) wdata[7:6] = 2'b00;
      tick_1hz = ($urandom % 12) == 0;
      pfail    = ($urandom % 24) == 0;
      if (($urandom % 8) == 0) cnt_q = {$urandom, $urandom};
      @(negedge clk);
    end
    ce = 0; we = 0; oe = 0; tick_1hz = 0; pfail = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule